// File: doc/BRIEF.md
# Two-Phase Decimal Accumulator Processor

This block is a very small one-address processor whose words are three decimal digits, each held as a 4-bit BCD nibble. It steps through a fixed rhythm of one fetch cycle followed by one execute cycle. In the fetch cycle it reads the word at the program counter into its instruction register. In the execute cycle it carries out that instruction against a single accumulator and, at most, one memory location. All memory traffic goes through an address register, a data register and a write flag, and these are brought out as ports so that a bench can watch them.

The 100-word memory is inside the block. A preload port writes it, normally while reset is held, so that a program and its data are in place before the first fetch. Arithmetic is decimal and wraps at 1000. A halt instruction freezes the machine until the next reset.

Top module: `dec_acc_cpu`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pc_o` = 0, `acc_o` = 000, `exec_o` = 0 (fetch) and `halted_o` = 0.
- R2: A word is three BCD digits. Bits [11:8] hold the opcode digit, bits [7:4] the tens digit of the address and bits [3:0] the units digit. Phases alternate: fetch (`exec_o`=0) puts `pc_o` on `mar_o` and latches `mdr_o` into the instruction register. Execute (`exec_o`=1) of a word with a nonzero opcode digit puts its address field, converted to binary, on `mar_o`.
- R3: Every executed instruction that is neither a jump nor a halt advances `pc_o` by one. The count wraps from 99 to 0.
- R4: Opcode 1 (load, 1aa) sets the accumulator to the word at address aa.
- R5: Opcode 2 (store, 2aa) raises `wr_o` for its execute cycle only, with `mar_o` = aa and `mdr_o` = accumulator. The memory holds that value from the next clock edge, so a later load of aa returns it.
- R6: Opcode 3 (3aa) replaces the accumulator with the decimal sum of the accumulator and word aa, modulo 1000.
- R7: Opcode 4 (4aa) replaces the accumulator with accumulator minus word aa, modulo 1000, using ten's complement.
- R8: Opcode 5 (5aa) loads aa into the program counter. The word that follows the jump is not executed.
- R9: Word 001 clears the accumulator to 000. Word 002 adds one to it, with 999 going to 000.
- R10: Word 000 raises `halted_o` at the end of its execute cycle. From then until reset, `pc_o` keeps the address of the halt word, the accumulator and phase do not change, and `wr_o` stays low.
- R11: Every other word acts as a no-op. This covers opcodes 6 to 9, and opcode 0 with any address field other than 00, 01 or 02. A no-op leaves the accumulator alone, does not write memory and advances the program counter.
- R12: While `preload_en` is high, the clock edge writes `preload_data` into memory at binary address `preload_addr` (0 to 99).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preload_en | input | 1 | Memory preload strobe |
| preload_addr | input | 7 | Preload address, binary 0 to 99 |
| preload_data | input | 12 | Preload word, three BCD digits |
| pc_o | output | 7 | Program counter, binary |
| acc_o | output | 12 | Accumulator, three BCD digits |
| exec_o | output | 1 | 0 = fetch phase, 1 = execute phase |
| mar_o | output | 7 | Memory address register, binary |
| mdr_o | output | 12 | Memory data register |
| wr_o | output | 1 | Memory write flag |
| halted_o | output | 1 | Machine halted |

## Verification
The bench sweeps the add and subtract paths over a grid of operand pairs that includes 0, 1, 500 and 999. This catches a missing decimal adjust or a lost end-around carry, either of which would give a non-BCD digit or a result one off. A self-modifying program stores a halt word into address 0 from address 99, which exposes a program counter that fails to wrap or that leaves the range. A jump whose successor would clear the accumulator, and a run of no-op codes between stores, catch a design that executes the word after a jump, or that lets an unused code write memory or touch the accumulator. After a halt the bench waits ten cycles and checks that nothing moves.

// File: rtl/dec_acc_cpu.sv
module dec_acc_cpu #(
  parameter int WORDS = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        preload_en,
  input  logic [6:0]  preload_addr,
  input  logic [11:0] preload_data,
  output logic [6:0]  pc_o,
  output logic [11:0] acc_o,
  output logic        exec_o,
  output logic [6:0]  mar_o,
  output logic [11:0] mdr_o,
  output logic        wr_o,
  output logic        halted_o
);

  localparam int AW = 7;
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  function automatic logic [11:0] bcd_add(input logic [11:0] a, input logic [11:0] b,
                                          input logic cin);
    logic       c;
    logic [4:0] s;
    logic [11:0] r;
    c = cin;
    r = '0;
    for (int i = 0; i < 3; i++) begin
      s = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'b0, c};
      if (s > 5'd9) begin
        s = s + 5'd6;
        c = 1'b1;
      end else begin
        c = 1'b0;
      end
      r[4*i +: 4] = s[3:0];
    end
    return r;
  endfunction

  function automatic logic [11:0] nines(input logic [11:0] x);
    logic [11:0] r;
    for (int i = 0; i < 3; i++) r[4*i +: 4] = 4'd9 - x[4*i +: 4];
    return r;
  endfunction

  logic [11:0] mem [0:WORDS-1];
  logic [AW-1:0] pc, pc_n, pc_inc;
  logic [11:0] acc, acc_n, ir, rd;
  logic exec, halted, halt_n;

  wire [3:0]    op    = ir[11:8];
  wire [AW-1:0] field = {3'b0, ir[7:4]} * 7'd10 + {3'b0, ir[3:0]};
  wire [AW-1:0] mar   = (exec && op != 4'd0) ? field : pc;
  wire          wr    = exec && !halted && op == 4'd2 && mar < AW'(WORDS);
  wire [11:0]   mdr   = wr ? acc : rd;

  assign rd     = (mar < AW'(WORDS)) ? mem[mar] : '0;
  assign pc_inc = (pc == LAST) ? '0 : pc + 1'b1;

  always_comb begin
    acc_n  = acc;
    pc_n   = pc_inc;
    halt_n = 1'b0;
    case (op)
      4'd1: acc_n = rd;
      4'd3: acc_n = bcd_add(acc, rd, 1'b0);
      4'd4: acc_n = bcd_add(acc, nines(rd), 1'b1);
      4'd5: pc_n  = (field < AW'(WORDS)) ? field : '0;
      4'd0: begin
        if (ir[7:0] == 8'h00) begin
          halt_n = 1'b1;
          pc_n   = pc;
        end else if (ir[7:0] == 8'h01) begin
          acc_n = '0;
        end else if (ir[7:0] == 8'h02) begin
          acc_n = bcd_add(acc, 12'h000, 1'b1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      acc    <= '0;
      ir     <= '0;
      exec   <= 1'b0;
      halted <= 1'b0;
    end else if (!halted) begin
      if (!exec) begin
        ir   <= mdr;
        exec <= 1'b1;
      end else begin
        acc    <= acc_n;
        pc     <= pc_n;
        halted <= halt_n;
        exec   <= halt_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (preload_en) begin
      if (preload_addr < AW'(WORDS)) mem[preload_addr] <= preload_data;
    end else if (wr) begin
      mem[mar] <= acc;
    end
  end

  assign pc_o     = pc;
  assign acc_o    = acc;
  assign exec_o   = exec;
  assign mar_o    = mar;
  assign mdr_o    = mdr;
  assign wr_o     = wr;
  assign halted_o = halted;

  a_r3_pc_range: assert property (@(posedge clk) disable iff (!rst_n)
    pc < AW'(WORDS));

  a_r2_phase_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |=> (halted || exec != $past(exec)));

  a_r2_ir_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec && !halted) |=> ir == $past(mdr));

  a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !halted && op != 4'd5 && ir != 12'h000)
      |=> pc == (($past(pc) == LAST) ? '0 : $past(pc) + 1'b1));

  a_r10_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && exec && $stable(pc) && $stable(acc) && !wr));

  a_r5_write_exec_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (exec && !halted && op == 4'd2));

endmodule

// File: tb/dec_acc_cpu_tb_top.sv
`timescale 1ns/1ps
module dec_acc_cpu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        preload_en = 1'b0;
  logic [6:0]  preload_addr = '0;
  logic [11:0] preload_data = '0;
  logic [6:0]  pc_o, mar_o;
  logic [11:0] acc_o, mdr_o;
  logic        exec_o, wr_o, halted_o;

  int n_chk = 0;
  int n_fail = 0;
  int wcount = 0;
  logic [11:0] shadow [0:99];
  logic        wrote  [0:99];

  always #2.5 clk = ~clk;

  dec_acc_cpu dut_i (
    .clk(clk), .rst_n(rst_n), .preload_en(preload_en), .preload_addr(preload_addr),
    .preload_data(preload_data), .pc_o(pc_o), .acc_o(acc_o), .exec_o(exec_o),
    .mar_o(mar_o), .mdr_o(mdr_o), .wr_o(wr_o), .halted_o(halted_o)
  );

  always @(negedge clk) begin
    if (rst_n && wr_o) begin
      shadow[mar_o] = mdr_o;
      wrote[mar_o]  = 1'b1;
      wcount        = wcount + 1;
    end
  end

  function automatic logic [11:0] tobcd(input int v);
    return {4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic begin_load();
    @(negedge clk);
    rst_n  = 1'b0;
    wcount = 0;
    for (int i = 0; i < 100; i++) wrote[i] = 1'b0;
  endtask

  task automatic pl(input int a, input logic [11:0] d);
    preload_addr = 7'(a);
    preload_data = d;
    preload_en   = 1'b1;
    @(negedge clk);
    preload_en   = 1'b0;
  endtask

  task automatic run(input string tag);
    int n;
    rst_n = 1'b1;
    n = 0;
    while (!halted_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " halts"}, 32'(halted_o), 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [11:0] hold_acc;
    logic [6:0]  hold_pc;
    int hold_w;

    // arithmetic program, also used for reset and phase checks
    begin_load();
    pl(0, 12'h110); pl(1, 12'h311); pl(2, 12'h212); pl(3, 12'h110);
    pl(4, 12'h411); pl(5, 12'h213); pl(6, 12'h000);
    pl(10, 12'h003); pl(11, 12'h005);
    chk("R1 pc in reset", 32'(pc_o), 0);
    chk("R1 acc in reset", 32'(acc_o), 0);
    chk("R1 phase in reset", 32'(exec_o), 0);
    chk("R1 halted in reset", 32'(halted_o), 0);
    rst_n = 1'b1;
    chk("R1 pc after release", 32'(pc_o), 0);
    chk("R2 fetch address", 32'(mar_o), 0);
    chk("R2 fetch word", 32'(mdr_o), 32'h110);
    @(negedge clk);
    chk("R2 execute phase", 32'(exec_o), 1);
    chk("R2 execute address", 32'(mar_o), 10);
    chk("R4 load data", 32'(mdr_o), 32'h003);
    @(negedge clk);
    chk("R2 back to fetch", 32'(exec_o), 0);
    chk("R3 pc step", 32'(pc_o), 1);
    chk("R4 acc after load", 32'(acc_o), 32'h003);
    chk("R2 next fetch address", 32'(mar_o), 1);
    run("R10 arith");
    chk("R6 3+5", 32'(shadow[12]), 32'h008);
    chk("R7 3-5", 32'(acc_o), 32'h998);

    // add/subtract sweep
    for (int i = 0; i < 30; i++) begin
      for (int j = 0; j < 27; j++) begin
        int a, b;
        a = (i == 27) ? 999 : (i == 28) ? 500 : (i == 29) ? 1 : i * 37;
        b = (j == 25) ? 999 : (j == 26) ? 1 : j * 41;
        begin_load();
        pl(10, tobcd(a)); pl(11, tobcd(b));
        run("R10 sweep");
        chk("R6 sum", 32'(shadow[12]), 32'(tobcd((a + b) % 1000)));
        chk("R7 difference", 32'(shadow[13]), 32'(tobcd((a - b + 1000) % 1000)));
        chk("R5 store count", 32'(wcount), 2);
      end
    end

    // jump skips the following word
    begin_load();
    pl(0, 12'h002); pl(1, 12'h540); pl(2, 12'h001); pl(40, 12'h002); pl(41, 12'h000);
    run("R8 jump");
    chk("R8 acc after jump", 32'(acc_o), 32'h002);
    chk("R8 pc at target halt", 32'(pc_o), 41);

    // pc wrap with self-modifying store at 99
    begin_load();
    pl(0, 12'h598); pl(98, 12'h160); pl(99, 12'h200); pl(60, 12'h000);
    run("R3 wrap");
    chk("R3 pc wrapped to 0", 32'(pc_o), 0);
    chk("R5 store to 00", 32'(wrote[0]), 1);
    chk("R5 stored halt word", 32'(shadow[0]), 32'h000);

    // clear, increment, no-ops, halt freeze
    begin_load();
    pl(0, 12'h150); pl(1, 12'h002); pl(2, 12'h260); pl(3, 12'h002);
    pl(4, 12'h002); pl(5, 12'h261); pl(6, 12'h600); pl(7, 12'h799);
    pl(8, 12'h003); pl(9, 12'h050); pl(10, 12'h262); pl(11, 12'h001);
    pl(12, 12'h263); pl(13, 12'h000); pl(50, 12'h999);
    run("R9 misc");
    chk("R9 increment wraps 999", 32'(shadow[60]), 32'h000);
    chk("R9 increment twice", 32'(shadow[61]), 32'h002);
    chk("R11 no-ops keep acc", 32'(shadow[62]), 32'h002);
    chk("R9 clear", 32'(shadow[63]), 32'h000);
    chk("R11 no-ops write nothing", 32'(wcount), 4);
    chk("R10 pc holds halt address", 32'(pc_o), 13);
    hold_acc = acc_o;
    hold_pc  = pc_o;
    hold_w   = wcount;
    repeat (10) @(negedge clk);
    chk("R10 halted stays", 32'(halted_o), 1);
    chk("R10 pc frozen", 32'(pc_o), 32'(hold_pc));
    chk("R10 acc frozen", 32'(acc_o), 32'(hold_acc));
    chk("R10 phase frozen", 32'(exec_o), 1);
    chk("R10 no writes", 32'(wcount), 32'(hold_w));
    rst_n = 1'b0;
    #1;
    chk("R1 reset clears halt", 32'(halted_o), 0);
    chk("R1 reset clears pc", 32'(pc_o), 0);

    // store then load back
    begin_load();
    pl(0, 12'h150); pl(1, 12'h270); pl(2, 12'h151); pl(3, 12'h170); pl(4, 12'h000);
    pl(50, 12'h123); pl(51, 12'h456); pl(70, 12'h999);
    run("R5 readback");
    chk("R5 load returns stored word", 32'(acc_o), 32'h123);

    // preload at the edge addresses
    begin_load();
    pl(0, 12'h199); pl(1, 12'h398); pl(2, 12'h000); pl(99, 12'h777); pl(98, 12'h222);
    run("R12 preload");
    chk("R12 edge words", 32'(acc_o), 32'h999);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule